// File: doc/BRIEF.md
# PCI Host Bridge Control Register Block

This block is the register file a PCI host bridge exposes to the processor side. A 64-bit register bus reaches it with 4-byte or 8-byte accesses. It returns a fixed function-class code and reports the bridge's bus number, replicated as first and last bus of the range. It stores an arbitration mask, a status/control word, an error configuration word and a bank of MMIO window base/mask pairs. The window pairs come out of reset holding values set by a parameter.

Each 64-bit register can be written whole or one 32-bit half at a time, and read the same ways. Offsets that decode to no register are handled by a hard-fail switch in bit 0 of the status/control word. With the switch on, the access returns an error response. With it off, a read returns all ones and a write is discarded. Every accepted request gets exactly one response on the following cycle.

Top module: `hbr_ctrl_regs`

## Requirements
- R1: After synchronous reset the arbitration mask, status/control and error configuration registers read zero, and window entry i reads the i-th 64-bit slice of parameter WIN_INIT.
- R2: `req_ready` is low during reset and high afterwards. Every accepted request (`req_valid` and `req_ready`) yields `rsp_valid` high on the next cycle only, and no response appears without a request.
- R3: An 8-byte access (`req_wide`=1) to arbitration mask (0x010), status/control (0x018) or error configuration (0x030) writes or reads all 64 bits.
- R4: A 4-byte write (`req_wide`=0) takes its data from `req_wdata[31:0]`. When address bit 2 is 1 it replaces bits 63:32 and keeps bits 31:0. When bit 2 is 0 it replaces bits 31:0 and keeps bits 63:32.
- R5: A 4-byte read returns, in `rsp_rdata[31:0]`, the half selected by address bit 2 (1 = upper), and `rsp_rdata[63:32]` is zero.
- R6: Offset 0x000 reads 0x6000005, and writes to it change nothing.
- R7: Offset 0x008 reads the `bus_num` input in bits 7:0 and again in bits 15:8, with all other bits zero. Writes to it change nothing.
- R8: Offsets 0x200 to 0x24F hold NWIN=10 writable 64-bit window entries, and entry index = (offset - 0x200)/8. Offsets just outside that range are unmapped.
- R9: Offset 0x038 (error status) always reads zero, and writes to it complete without error and change nothing.
- R10: With status/control bit 0 set, an access to an unmapped offset returns `rsp_err`=1 with `rsp_rdata` zero, and a write changes no register.
- R11: With status/control bit 0 clear, a read of an unmapped offset returns all ones (a 4-byte read returns 0xFFFFFFFF in bits 31:0). A write to it is dropped, and `rsp_err` stays 0.
- R12: Decode ignores address bits 2:0, apart from the half selection that bit 2 makes for 4-byte accesses. A write response carries zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_num | input | BUSNUM_W (5) | Bus number reported by the scratch register |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 8-byte access, 0 = 4-byte access |
| req_addr | input | ADDR_W (12) | Byte offset within the block |
| req_wdata | input | 64 | Write data (4-byte writes use bits 31:0) |
| rsp_valid | output | 1 | Response present, one cycle after acceptance |
| rsp_err | output | 1 | Decode error response |
| rsp_rdata | output | 64 | Read data |

## Verification
The hardest case is the one where the hard-fail switch changes how a later access is reported. The bench writes status/control and then, on the very next cycle, issues an unmapped access, so the new switch value must already be in effect. A rejected write leaves no trace at the ports. The stimulus therefore reads back a register written earlier and shows that it is unchanged. Half writes are made in both orders on the same register, so each half can be seen to survive a write to the other.

// File: rtl/hbr_pkg.sv
package hbr_pkg;

  typedef enum logic [2:0] {
    K_FCLASS, K_BUSNUM, K_ARB, K_STAT, K_ERRCFG, K_ERRSTAT, K_WIN, K_NONE
  } reg_kind_e;

  localparam int unsigned OFF_FCLASS  = 'h000;
  localparam int unsigned OFF_BUSNUM  = 'h008;
  localparam int unsigned OFF_ARB     = 'h010;
  localparam int unsigned OFF_STAT    = 'h018;
  localparam int unsigned OFF_ERRCFG  = 'h030;
  localparam int unsigned OFF_ERRSTAT = 'h038;

  localparam logic [63:0] FCLASS_VALUE = 64'h0000_0000_0600_0005;

  // Merge a full or half-width write into a 64-bit register image.
  function automatic logic [63:0] merge_half(input logic [63:0] old_v,
                                             input logic [63:0] wdata,
                                             input logic        wide,
                                             input logic        hi);
    if (wide)    return wdata;
    else if (hi) return {wdata[31:0], old_v[31:0]};
    else         return {old_v[63:32], wdata[31:0]};
  endfunction

endpackage

// File: rtl/hbr_decode.sv
module hbr_decode
  import hbr_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int NWIN     = 10,
  parameter int WIN_BASE = 'h200,
  parameter int IDX_W    = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_kind_e         kind,
  output logic [IDX_W-1:0]  win_idx
);
  localparam int unsigned WIN_END = WIN_BASE + 8 * NWIN;

  logic [ADDR_W-1:0] aligned;
  int unsigned       ai;

  always_comb begin
    aligned = addr & ~ADDR_W'(7);
    ai      = int'(aligned);
    win_idx = '0;
    kind    = K_NONE;
    if (ai >= WIN_BASE && ai < WIN_END) begin
      kind    = K_WIN;
      win_idx = IDX_W'((ai - WIN_BASE) >> 3);
    end else begin
      case (ai)
        OFF_FCLASS:  kind = K_FCLASS;
        OFF_BUSNUM:  kind = K_BUSNUM;
        OFF_ARB:     kind = K_ARB;
        OFF_STAT:    kind = K_STAT;
        OFF_ERRCFG:  kind = K_ERRCFG;
        OFF_ERRSTAT: kind = K_ERRSTAT;
        default:     kind = K_NONE;
      endcase
    end
  end

endmodule

// File: rtl/hbr_win_bank.sv
module hbr_win_bank
  import hbr_pkg::*;
#(
  parameter int               NWIN     = 10,
  parameter int               IDX_W    = 4,
  parameter logic [NWIN*64-1:0] WIN_INIT = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic             wide,
  input  logic             hi,
  input  logic [63:0]      wdata,
  output logic [63:0]      rdata
);
  logic [63:0] win [NWIN];

  for (genvar i = 0; i < NWIN; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst)
        win[i] <= WIN_INIT[i*64 +: 64];
      else if (we && idx == IDX_W'(i))
        win[i] <= merge_half(win[i], wdata, wide, hi);
    end

    // R4: upper-half write leaves lower half alone
    p_hi_keeps_lo_r4: assert property (@(posedge clk) disable iff (rst)
      (we && !wide && hi && idx == IDX_W'(i)) |=> win[i][31:0] == $past(win[i][31:0]));
    // R4: lower-half write leaves upper half alone
    p_lo_keeps_hi_r4: assert property (@(posedge clk) disable iff (rst)
      (we && !wide && !hi && idx == IDX_W'(i)) |=> win[i][63:32] == $past(win[i][63:32]));
  end

  always_comb begin
    rdata = '0;
    for (int j = 0; j < NWIN; j++)
      if (idx == IDX_W'(j)) rdata = win[j];
  end

endmodule

// File: rtl/hbr_ctrl_regs.sv
module hbr_ctrl_regs
  import hbr_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int BUSNUM_W = 5,
  parameter int NWIN     = 10,
  parameter int WIN_BASE = 'h200,
  parameter logic [NWIN*64-1:0] WIN_INIT = {
    64'h0000_0000_0000_E000, 64'h0000_0000_0000_0001,
    64'h0000_00FC_0000_0000, 64'h0000_00F8_0000_0001,
    64'h0000_0000_F000_0000, 64'h0000_0000_F000_0001,
    64'h0000_00FF_8000_0000, 64'h0000_00F8_0000_0001,
    64'h0000_0000_F800_0000, 64'h0000_0000_F000_0001}
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [BUSNUM_W-1:0] bus_num,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic                req_wide,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [63:0]         req_wdata,
  output logic                rsp_valid,
  output logic                rsp_err,
  output logic [63:0]         rsp_rdata
);
  localparam int IDX_W = (NWIN > 1) ? $clog2(NWIN) : 1;

  reg_kind_e        kind;
  logic [IDX_W-1:0] win_idx;
  logic [63:0]      win_rdata;
  logic [63:0]      arb_q, stat_q, errcfg_q;
  logic [63:0]      full_v, rd_v;
  logic             acc, hi, hard_fail, unmapped;

  hbr_decode #(.ADDR_W(ADDR_W), .NWIN(NWIN), .WIN_BASE(WIN_BASE), .IDX_W(IDX_W)) u_dec (
    .addr(req_addr), .kind(kind), .win_idx(win_idx));

  assign acc       = req_valid && req_ready;
  assign hi        = req_addr[2];
  assign hard_fail = stat_q[0];
  assign unmapped  = (kind == K_NONE);

  hbr_win_bank #(.NWIN(NWIN), .IDX_W(IDX_W), .WIN_INIT(WIN_INIT)) u_win (
    .clk(clk), .rst(rst),
    .we(acc && req_write && kind == K_WIN),
    .idx(win_idx), .wide(req_wide), .hi(hi), .wdata(req_wdata),
    .rdata(win_rdata));

  always_ff @(posedge clk) begin
    if (rst) begin
      arb_q    <= '0;
      stat_q   <= '0;
      errcfg_q <= '0;
    end else if (acc && req_write) begin
      case (kind)
        K_ARB:    arb_q    <= merge_half(arb_q, req_wdata, req_wide, hi);
        K_STAT:   stat_q   <= merge_half(stat_q, req_wdata, req_wide, hi);
        K_ERRCFG: errcfg_q <= merge_half(errcfg_q, req_wdata, req_wide, hi);
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (kind)
      K_FCLASS:  full_v = FCLASS_VALUE;
      K_BUSNUM:  full_v = 64'(bus_num) | (64'(bus_num) << 8);
      K_ARB:     full_v = arb_q;
      K_STAT:    full_v = stat_q;
      K_ERRCFG:  full_v = errcfg_q;
      K_WIN:     full_v = win_rdata;
      K_NONE:    full_v = hard_fail ? 64'd0 : {64{1'b1}};
      default:   full_v = '0;
    endcase
    if (req_write)     rd_v = '0;
    else if (req_wide) rd_v = full_v;
    else               rd_v = {32'd0, hi ? full_v[63:32] : full_v[31:0]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_ready <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      req_ready <= 1'b1;
      rsp_valid <= acc;
      rsp_err   <= acc && unmapped && hard_fail;
      rsp_rdata <= acc ? rd_v : '0;
    end
  end

  p_rsp_follows_req_r2: assert property (@(posedge clk) disable iff (rst)
    acc |=> rsp_valid);
  p_no_spurious_rsp_r2: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(acc));
  p_err_needs_hf_r10: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> $past(stat_q[0]) && rsp_rdata == 64'd0);
  p_narrow_upper_zero_r5: assert property (@(posedge clk) disable iff (rst)
    $past(acc && !req_write && !req_wide) |-> rsp_rdata[63:32] == 32'd0);
  p_fclass_const_r6: assert property (@(posedge clk) disable iff (rst)
    $past(acc && !req_write && req_wide && kind == K_FCLASS) |-> rsp_rdata == FCLASS_VALUE);
  p_errstat_zero_r9: assert property (@(posedge clk) disable iff (rst)
    $past(acc && kind == K_ERRSTAT) |-> rsp_rdata == 64'd0 && !rsp_err);

endmodule

// File: tb/hbr_ctrl_regs_tb.sv
`timescale 1ns/1ps
module hbr_ctrl_regs_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  bus_num = 5'h13;
  logic        req_valid = 1'b0, req_write = 1'b0, req_wide = 1'b0;
  logic [11:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic        req_ready, rsp_valid, rsp_err;
  logic [63:0] rsp_rdata;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [64:0] exp_q[$];
  string       tag_q[$];

  localparam logic [63:0] ONES = {64{1'b1}};
  localparam logic [63:0] W0 = 64'h0000_0000_F000_0001, W6 = 64'h0000_00F8_0000_0001,
                          W9 = 64'h0000_0000_0000_E000;

  always #2 clk = ~clk;

  hbr_ctrl_regs u_dut (.clk(clk), .rst(rst), .bus_num(bus_num), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_wide(req_wide), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata));

  task automatic chk(string tag, logic [64:0] act, logic [64:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual err=%0b data=%h expected err=%0b data=%h",
               tag, act[64], act[63:0], exp[64], exp[63:0]);
    end
  endtask

  // Monitor: pops expected responses as the design produces them.
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (exp_q.size() == 0) chk("R2 spurious response", {rsp_err, rsp_rdata}, 65'h1_DEAD_DEAD_DEAD_DEAD);
      else chk(tag_q.pop_front(), {rsp_err, rsp_rdata}, exp_q.pop_front());
    end
  end

  // Driver: one request per cycle, expected response queued alongside.
  task automatic acc(logic w, logic wide, logic [11:0] a, logic [63:0] d,
                     logic [63:0] ed, logic ee, string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_wide = wide; req_addr = a; req_wdata = d;
    exp_q.push_back({ee, ed});
    tag_q.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R2 ready low in reset", {64'd0, req_ready}, 65'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R2 ready after reset", {64'd0, req_ready}, 65'd1);
    chk("R1 no response at reset", {64'd0, rsp_valid}, 65'd0);
    acc(0, 1, 12'h018, 0, 64'd0, 0, "R1 stat reset");
    acc(0, 1, 12'h010, 0, 64'd0, 0, "R1 arb reset");
    acc(0, 1, 12'h030, 0, 64'd0, 0, "R1 errcfg reset");
    acc(0, 1, 12'h200, 0, W0, 0, "R1 window0 default");
    acc(0, 1, 12'h248, 0, W9, 0, "R8 window9 default");
    // R3 full-width
    acc(1, 1, 12'h010, 64'hA5A5_5A5A_1234_5678, 64'd0, 0, "R3 write arb");
    acc(0, 1, 12'h010, 0, 64'hA5A5_5A5A_1234_5678, 0, "R3 read arb");
    // R4 half writes
    acc(1, 0, 12'h014, 64'h1111_1111_DEAD_BEEF, 64'd0, 0, "R4 hi write");
    acc(0, 1, 12'h010, 0, 64'hDEAD_BEEF_1234_5678, 0, "R4 hi merge");
    acc(1, 0, 12'h010, 64'h2222_2222_0BAD_F00D, 64'd0, 0, "R4 lo write");
    acc(0, 1, 12'h010, 0, 64'hDEAD_BEEF_0BAD_F00D, 0, "R4 lo merge");
    acc(0, 0, 12'h014, 0, 64'h0000_0000_DEAD_BEEF, 0, "R5 narrow hi read");
    acc(0, 0, 12'h010, 0, 64'h0000_0000_0BAD_F00D, 0, "R5 narrow lo read");
    // R6 function class
    acc(0, 1, 12'h000, 0, 64'h600_0005, 0, "R6 fclass");
    acc(1, 1, 12'h000, ONES, 64'd0, 0, "R6 fclass write");
    acc(0, 1, 12'h000, 0, 64'h600_0005, 0, "R6 fclass after write");
    acc(0, 0, 12'h004, 0, 64'd0, 0, "R6 fclass upper half");
    // R7 bus number
    acc(0, 1, 12'h008, 0, 64'h1313, 0, "R7 bus num");
    acc(1, 1, 12'h008, ONES, 64'd0, 0, "R7 bus num write");
    acc(0, 1, 12'h008, 0, 64'h1313, 0, "R7 bus num after write");
    // R8 windows
    acc(1, 1, 12'h238, 64'h0123_4567_89AB_CDEF, 64'd0, 0, "R8 window7 write");
    acc(0, 1, 12'h238, 0, 64'h0123_4567_89AB_CDEF, 0, "R8 window7 read");
    acc(0, 1, 12'h230, 0, W6, 0, "R8 window6 untouched");
    acc(1, 0, 12'h23C, 64'h0000_0000_5555_AAAA, 64'd0, 0, "R4 window hi write");
    acc(0, 1, 12'h238, 0, 64'h5555_AAAA_89AB_CDEF, 0, "R4 window hi merge");
    // R9 error status
    acc(1, 1, 12'h038, ONES, 64'd0, 0, "R9 errstat write");
    acc(0, 1, 12'h038, 0, 64'd0, 0, "R9 errstat read");
    // R11 unmapped, hard-fail off
    acc(0, 1, 12'h100, 0, ONES, 0, "R11 unmapped wide read");
    acc(0, 0, 12'h104, 0, 64'h0000_0000_FFFF_FFFF, 0, "R11 unmapped narrow read");
    acc(1, 1, 12'h100, 64'h77, 64'd0, 0, "R11 unmapped write dropped");
    // R12 low address bits
    acc(0, 1, 12'h013, 0, 64'hDEAD_BEEF_0BAD_F00D, 0, "R12 bits 1:0 ignored");
    acc(0, 1, 12'h014, 0, 64'hDEAD_BEEF_0BAD_F00D, 0, "R12 wide ignores bit 2");
    acc(0, 0, 12'h017, 0, 64'h0000_0000_DEAD_BEEF, 0, "R12 narrow hi with bits 1:0");
    acc(0, 1, 12'h24F, 0, W9, 0, "R12 window9 top byte");
    // R10 hard-fail on, used on the very next cycle
    acc(1, 1, 12'h018, 64'd1, 64'd0, 0, "R3 write stat");
    acc(0, 1, 12'h100, 0, 64'd0, 1, "R10 unmapped read err");
    acc(1, 1, 12'h0F8, ONES, 64'd0, 1, "R10 unmapped write err");
    acc(0, 0, 12'h104, 0, 64'd0, 1, "R10 narrow unmapped err");
    acc(0, 1, 12'h250, 0, 64'd0, 1, "R8 past window end");
    acc(0, 1, 12'h1F8, 0, 64'd0, 1, "R8 before window start");
    acc(0, 1, 12'h010, 0, 64'hDEAD_BEEF_0BAD_F00D, 0, "R10 arb unchanged");
    acc(0, 1, 12'h018, 0, 64'd1, 0, "R3 read stat");
    idle();
    repeat (3) @(negedge clk);
    chk("R2 all responses seen", {33'd0, 32'(exp_q.size())}, 65'd0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule